// File: doc/BRIEF.md
# Card Interface Power-Down Controller

This block decides when the signal drivers of a 16-bit card socket are switched on, when the card is held in reset, and when a pending access may proceed. Two software controls feed it. A manual output-disable control puts the card signals into high impedance and holds the card in reset. An automatic power-down mode puts the signals into the same high-impedance state only after the card has been idle for a programmable number of clocks, and it leaves the card out of reset so that card state survives the power-down.

Any new access request or card activity ends an automatic power-down. The drivers are turned back on at once, and the ready indication follows after a fixed settle time. Leaving the manual disable goes through the same settle time. The card reset is also stretched for a few clocks past the release so that the card sees a clean reset pulse. Register decoding and the card protocol engine sit outside this block. It takes the control bits, an activity flag and an access strobe, and it drives the enable, reset and ready lines.

Top module: `card_pwr_ctl`

## Requirements
- R1: After a synchronous reset, `if_oe` is 1, `card_rst` is 0 and `acc_rdy` is 1. The idle count is zero and no power-down is in effect.
- R2: While `oe_off` is sampled high, `if_oe` and `acc_rdy` are both 0 from the next clock on.
- R3: `card_rst` is 1 from the clock after `oe_off` is first sampled high, for as long as `oe_off` stays high. It then stays 1 for exactly RST_HOLD_CLKS (default 4) further clocks after the first clock edge that samples `oe_off` low.
- R4: Automatic power-down never raises `card_rst`. A reset pulse only ever begins one clock after `oe_off` was sampled high.
- R5: With `auto_pd_en` high, a clock is idle when `card_busy` and `acc_req` are both 0. Counting from the return to the active state, once `idle_limit` idle clocks in a row have passed, the next idle clock drops `if_oe` and `acc_rdy` to 0 at its edge. That is the (idle_limit+1)-th idle edge in a row.
- R6: Any clock with `card_busy` or `acc_req` high sets the idle count back to zero.
- R7: In power-down, a clock with `acc_req` or `card_busy` high sets `if_oe` to 1 at its edge. `acc_rdy` then rises exactly SETTLE_CLKS (default 2) clocks later.
- R8: `oe_off` takes priority over every automatic power-down or settle state. The outputs follow R2 and R3 whatever `auto_pd_en` is.
- R9: Releasing `oe_off`, or clearing `auto_pd_en` while powered down, re-enables `if_oe` at the next edge. `acc_rdy` then rises after the same SETTLE_CLKS settle time.
- R10: While `auto_pd_en` is 0 and `oe_off` is 0, `if_oe` never falls, however long the card stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_off | input | 1 | Manual output disable; also resets the card |
| auto_pd_en | input | 1 | Enables idle-driven automatic power-down |
| idle_limit | input | IDLE_W | Idle clocks required before automatic power-down |
| card_busy | input | 1 | Card activity indication |
| acc_req | input | 1 | Access request strobe |
| if_oe | output | 1 | Card interface output enable (0 = high impedance) |
| card_rst | output | 1 | Card reset |
| acc_rdy | output | 1 | Pending accesses may proceed |

## Verification
The hardest situation to reach is the one where a stretched card reset and an automatic power-down overlap. This happens when `idle_limit` is 0 and `oe_off` is released with auto mode on. The block settles, goes active, and powers down again while `card_rst` is still counting out its hold. The bench sets up that overlap on purpose. It also raises `oe_off` in the middle of a settle window and while powered down. A behavioural model compares all three outputs on every clock.

// File: rtl/card_pwr_pkg.sv
package card_pwr_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_PDOWN  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_MANUAL = 2'd3
  } pwr_state_e;

endpackage

// File: rtl/cpd_idle_timer.sv
module cpd_idle_timer #(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              idle,
  input  logic [IDLE_W-1:0] limit,
  output logic              expired
);

  logic [IDLE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr || !idle) begin
      cnt_q <= '0;
    end else if (cnt_q != limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == limit);

  // R6: a busy clock leaves the count at zero for the following clock
  p_busy_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (!idle) |=> (cnt_q == '0));

endmodule

// File: rtl/cpd_reset_stretch.sv
module cpd_reset_stretch #(
  parameter int HOLD_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic force_rst,
  output logic card_rst
);

  localparam int HW = $clog2(HOLD_CLKS + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_CLKS);

  logic [HW-1:0] hold_q;
  logic          rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      rst_q  <= 1'b0;
    end else if (force_rst) begin
      hold_q <= HOLD_INIT;
      rst_q  <= 1'b1;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
      rst_q  <= 1'b1;
    end else begin
      rst_q  <= 1'b0;
    end
  end

  assign card_rst = rst_q;

  // R3: manual disable produces reset on the next clock
  p_force_rst_r3: assert property (@(posedge clk) disable iff (rst)
    force_rst |=> card_rst);

  // R4: a reset pulse only starts after the manual control was seen
  p_rst_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(card_rst) |-> $past(force_rst));

endmodule

// File: rtl/cpd_power_fsm.sv
module cpd_power_fsm
  import card_pwr_pkg::*;
#(
  parameter int SETTLE_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       oe_off,
  input  logic       auto_pd_en,
  input  logic       card_busy,
  input  logic       acc_req,
  input  logic       idle_expired,
  output pwr_state_e state,
  output logic       if_oe,
  output logic       acc_rdy
);

  localparam int SW = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CLKS - 1);

  pwr_state_e state_q, state_d;
  logic [SW-1:0] settle_q, settle_d;
  logic          oe_q, rdy_q;
  logic          idle_now, wake_req;

  assign idle_now = !card_busy && !acc_req;
  assign wake_req = acc_req || card_busy || !auto_pd_en;

  always_comb begin
    state_d  = state_q;
    settle_d = settle_q;
    if (oe_off) begin
      state_d  = ST_MANUAL;
      settle_d = '0;
    end else begin
      unique case (state_q)
        ST_ACTIVE: begin
          if (auto_pd_en && idle_now && idle_expired) state_d = ST_PDOWN;
        end
        ST_PDOWN: begin
          if (wake_req) begin
            state_d  = ST_SETTLE;
            settle_d = '0;
          end
        end
        ST_SETTLE: begin
          if (settle_q == SETTLE_LAST) begin
            state_d  = ST_ACTIVE;
            settle_d = '0;
          end else begin
            settle_d = settle_q + 1'b1;
          end
        end
        ST_MANUAL: begin
          state_d  = ST_SETTLE;
          settle_d = '0;
        end
        default: state_d = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_ACTIVE;
      settle_q <= '0;
      oe_q     <= 1'b1;
      rdy_q    <= 1'b1;
    end else begin
      state_q  <= state_d;
      settle_q <= settle_d;
      oe_q     <= (state_d == ST_ACTIVE) || (state_d == ST_SETTLE);
      rdy_q    <= (state_d == ST_ACTIVE);
    end
  end

  assign state   = state_q;
  assign if_oe   = oe_q;
  assign acc_rdy = rdy_q;

  // R2 / R8: manual disable wins over any automatic state
  p_manual_off_r2: assert property (@(posedge clk) disable iff (rst)
    oe_off |=> (!if_oe && !acc_rdy));

  // R7: an access in power-down turns drivers on but not ready yet
  p_wake_oe_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PDOWN && acc_req && !oe_off) |=> (if_oe && !acc_rdy));

  // R7 / R9: ready only rises after the drivers have been on
  p_settle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_rdy) |-> $past(if_oe));

  // R5: automatic power-down only when enabled
  p_pd_enabled_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && state_d == ST_PDOWN) |-> auto_pd_en);

endmodule

// File: rtl/card_pwr_ctl.sv
module card_pwr_ctl
  import card_pwr_pkg::*;
#(
  parameter int IDLE_W        = 8,
  parameter int SETTLE_CLKS   = 2,
  parameter int RST_HOLD_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_off,
  input  logic              auto_pd_en,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              card_busy,
  input  logic              acc_req,
  output logic              if_oe,
  output logic              card_rst,
  output logic              acc_rdy
);

  pwr_state_e state;
  logic       idle_expired;
  logic       timer_clr;

  assign timer_clr = (state != ST_ACTIVE);

  cpd_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .clr     (timer_clr),
    .idle    (!card_busy && !acc_req),
    .limit   (idle_limit),
    .expired (idle_expired)
  );

  cpd_power_fsm #(.SETTLE_CLKS(SETTLE_CLKS)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .oe_off       (oe_off),
    .auto_pd_en   (auto_pd_en),
    .card_busy    (card_busy),
    .acc_req      (acc_req),
    .idle_expired (idle_expired),
    .state        (state),
    .if_oe        (if_oe),
    .acc_rdy      (acc_rdy)
  );

  cpd_reset_stretch #(.HOLD_CLKS(RST_HOLD_CLKS)) u_rst (
    .clk       (clk),
    .rst       (rst),
    .force_rst (oe_off),
    .card_rst  (card_rst)
  );

  // R10: without auto mode or manual disable the drivers stay on
  p_no_auto_r10: assert property (@(posedge clk) disable iff (rst)
    (!auto_pd_en && !oe_off && if_oe) |=> if_oe);

  // R8: manual disable holds the card in reset regardless of auto mode
  p_prio_r8: assert property (@(posedge clk) disable iff (rst)
    (oe_off && auto_pd_en) |=> (card_rst && !if_oe));

endmodule

// File: tb/tb_card_pwr_ctl.sv
module tb_card_pwr_ctl;

  localparam int IDLE_W = 8;
  localparam int SETTLE = 2;
  localparam int HOLD   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_off = 1'b0, auto_pd_en = 1'b0, card_busy = 1'b0, acc_req = 1'b0;
  logic [IDLE_W-1:0] idle_limit = '0;
  logic if_oe, card_rst, acc_rdy;

  card_pwr_ctl #(.IDLE_W(IDLE_W), .SETTLE_CLKS(SETTLE), .RST_HOLD_CLKS(HOLD)) dut (
    .clk(clk), .rst(rst), .oe_off(oe_off), .auto_pd_en(auto_pd_en),
    .idle_limit(idle_limit), .card_busy(card_busy), .acc_req(acc_req),
    .if_oe(if_oe), .card_rst(card_rst), .acc_rdy(acc_rdy)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference: 0 active, 1 powered down, 2 settling, 3 manual
  int m_mode = 0, m_idle = 0, m_settle = 0, m_hold = 0;
  bit m_rst = 0;

  always @(posedge clk) begin
    int old_mode;
    bit quiet;
    cycles++;
    if (rst) begin
      m_mode = 0; m_idle = 0; m_settle = 0; m_hold = 0; m_rst = 0;
    end else begin
      old_mode = m_mode;
      quiet = !card_busy && !acc_req;
      if (oe_off) begin m_rst = 1; m_hold = HOLD; end
      else if (m_hold > 0) begin m_rst = 1; m_hold--; end
      else m_rst = 0;
      if (oe_off) begin m_mode = 3; m_settle = 0; end
      else if (old_mode == 0) begin
        if (auto_pd_en && quiet && m_idle == int'(idle_limit)) m_mode = 1;
      end else if (old_mode == 1) begin
        if (acc_req || card_busy || !auto_pd_en) begin m_mode = 2; m_settle = 0; end
      end else if (old_mode == 2) begin
        if (m_settle == SETTLE - 1) begin m_mode = 0; m_settle = 0; end
        else m_settle++;
      end else begin
        m_mode = 2; m_settle = 0;
      end
      if (old_mode != 0 || !quiet) m_idle = 0;
      else if (m_idle != int'(idle_limit)) m_idle++;
    end
  end

  task automatic check1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check1(cur_req, "if_oe",    if_oe,    (m_mode == 0 || m_mode == 2));
      check1(cur_req, "card_rst", card_rst, m_rst);
      check1(cur_req, "acc_rdy",  acc_rdy,  (m_mode == 0));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check1("R1", "reset if_oe", if_oe, 1'b1);
    check1("R1", "reset card_rst", card_rst, 1'b0);
    check1("R1", "reset acc_rdy", acc_rdy, 1'b1);
    @(posedge clk); #1;

    cur_req = "R10"; idle_limit = 8'd3; auto_pd_en = 1'b0;
    cyc(30);

    cur_req = "R5"; auto_pd_en = 1'b1; idle_limit = 8'd5;
    acc_req = 1'b1; cyc(1); acc_req = 1'b0;
    cyc(12);
    cur_req = "R4"; cyc(5);

    cur_req = "R7"; acc_req = 1'b1; cyc(1); acc_req = 1'b0;
    cyc(4);
    cur_req = "R6";
    for (int k = 0; k < 6; k++) begin
      cyc(4); card_busy = 1'b1; cyc(1); card_busy = 1'b0;
    end
    cyc(8);
    cur_req = "R7"; card_busy = 1'b1; cyc(1); card_busy = 1'b0;
    cyc(10);

    cur_req = "R9"; auto_pd_en = 1'b0; cyc(5);
    auto_pd_en = 1'b1; cyc(10);

    cur_req = "R3"; auto_pd_en = 1'b0; oe_off = 1'b1; cyc(6);
    cur_req = "R2"; cyc(2); oe_off = 1'b0;
    cur_req = "R3"; cyc(8);

    cur_req = "R8"; auto_pd_en = 1'b1; idle_limit = 8'd2; cyc(6);
    oe_off = 1'b1; cyc(3); oe_off = 1'b0; cyc(1);
    oe_off = 1'b1; cyc(2); oe_off = 1'b0;
    cyc(10);

    cur_req = "R3"; idle_limit = 8'd0; oe_off = 1'b1; cyc(3); oe_off = 1'b0;
    cyc(10);
    cur_req = "R9"; acc_req = 1'b1; cyc(1); acc_req = 1'b0;
    cyc(1); oe_off = 1'b1; cyc(1); oe_off = 1'b0; cyc(8);
    auto_pd_en = 1'b0; cyc(6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog (all requirements): actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule